// File: doc/BRIEF.md
# Flash write protection controller

This block keeps the protection state of a serial flash: the status register (write-in-progress, write enable latch, a three-bit block-protect field and a status-write-disable bit) and one small lock register per 64 KiB sector. For every request from the command decoder it decides in a single cycle whether the request may proceed. It answers with a one-cycle grant or deny pulse and updates its registers to match. The serial shifter and the memory array sit outside this block. The array signals the end of a self-timed cycle through `op_done_i`.

Requests carry an operation code, a byte address and a data byte. The status-write-disable bit and the active-low write-protect pin together form a hardware-protected mode that freezes the status register. Block protection covers a range of sectors counted down from the top of the array. Each sector's write-lock bit blocks program and erase in that sector. Its lock-down bit freezes both of its lock bits until the next reset, and reset stands in for power-up.

Top module: `flash_wprot`

## Requirements
- R1: After reset, `status_o` reads 00h, every sector lock register reads 00h, and `grant_o` and `deny_o` are low.
- R2: `status_o` bit 0 is write-in-progress, bit 1 is the write enable latch, bits 4:2 are the block-protect field, bit 7 is status-write-disable, and bits 6:5 read 0.
- R3: Op codes are 0 write-enable, 1 write-disable, 2 status write, 3 lock write, 4 program, 5 subsector erase, 6 sector erase and 7 bulk erase. An idle block grants write-enable, which sets the latch, and grants write-disable, which clears it. Any other request that is accepted or refused while idle leaves the latch cleared.
- R4: A status write is granted only when the latch is set and the part is not hardware-protected. When granted, it loads data bits 7 and 4:2 into the same positions, ignores the other data bits, and sets write-in-progress.
- R5: When status-write-disable is 1 and `wp_n_i` is low, a status write is denied and the status-write-disable bit and the block-protect field keep their values.
- R6: `lock_rd_o` shows the lock register of sector `lock_rd_sect_i`, with bit 0 as write-lock, bit 1 as lock-down and the other bits 0. A lock write to the sector in address bits [20:16] is granted only when the latch is set, and it loads data bits 1:0.
- R7: Once a sector's lock-down bit is 1, lock writes to that sector are denied and both of its bits hold until reset.
- R8: A block-protect value n from 1 to 7 protects the top min(2^(n-1), 32) sectors. A value of 0 protects none.
- R9: Program, subsector erase and sector erase are granted only when the latch is set, the target sector is not write-locked and the target sector is outside the protected range. A grant sets write-in-progress.
- R10: Bulk erase is granted only when the latch is set and the block-protect field is 0.
- R11: While write-in-progress is 1, every request is denied and changes no register. A pulse on `op_done_i` clears write-in-progress.
- R12: Each request gets exactly one of grant or deny, in the cycle after it is presented, and neither pulse appears without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (power-up) |
| cmd_valid_i | input | 1 | Request strobe, one cycle per request |
| cmd_op_i | input | 3 | Operation code (see R3) |
| cmd_addr_i | input | 21 | Byte address; bits [20:16] select the sector |
| cmd_wdata_i | input | 8 | Data byte for status and lock writes |
| wp_n_i | input | 1 | Write-protect pin, active low |
| op_done_i | input | 1 | Array reports the end of a self-timed cycle |
| lock_rd_sect_i | input | 5 | Sector whose lock register is read |
| status_o | output | 8 | Status register |
| lock_rd_o | output | 8 | Lock register of the selected sector |
| grant_o | output | 1 | Request accepted (one-cycle pulse) |
| deny_o | output | 1 | Request refused (one-cycle pulse) |

## Verification
The properties assume three things about the inputs: every request strobe is a single isolated cycle, `op_done_i` is pulsed only while write-in-progress is set, and the sector select for lock reads changes only when the bench means to read a different sector. The bench's driver leaves an idle cycle after each request and pulses the done line only after a granted status write, program or erase. It sets the read sector and then waits before sampling. The stimulus covers hardware-protected mode, each block-protect span including the capped values 6 and 7, and a locked sector next to an unlocked one. It also exercises lock-down across a second reset.

// File: rtl/fwp_pkg.sv
// Package: shared field positions and operation codes for the flash
// write protection controller.
package fwp_pkg;
    localparam int SR_WIP    = 0;
    localparam int SR_WEL    = 1;
    localparam int SR_BP_LSB = 2;
    localparam int SR_BP_W   = 3;
    localparam int SR_SRWD   = 7;

    typedef enum logic [2:0] {
        OP_WREN      = 3'd0,
        OP_WRDI      = 3'd1,
        OP_WRSR      = 3'd2,
        OP_WRLR      = 3'd3,
        OP_PROG      = 3'd4,
        OP_SUBERASE  = 3'd5,
        OP_SECTERASE = 3'd6,
        OP_BULKERASE = 3'd7
    } fwp_op_e;
endpackage

// File: rtl/fwp_bp_decode.sv
// Block-protect range decoder.
// Given the block-protect field and a sector number, it says whether the
// sector lies in the protected top range. The range size is 2^(n-1)
// sectors, capped at the sector count. Purely combinational.
module fwp_bp_decode #(
    parameter int SECT_W = 5,
    parameter int BP_W   = 3
) (
    input  logic [BP_W-1:0]   bp_i,
    input  logic [SECT_W-1:0] sect_i,
    output logic              hit_o
);
    localparam int NUM_SECT = 1 << SECT_W;

    int span;

    // Work out how many top sectors are covered, then compare.
    always_comb begin
        if (bp_i == '0) begin
            span = 0;
        end else if ((int'(bp_i) - 1) >= SECT_W) begin
            span = NUM_SECT;
        end else begin
            span = 1 << (int'(bp_i) - 1);
        end
        hit_o = (span != 0) && (int'(sect_i) >= (NUM_SECT - span));
    end
endmodule

// File: rtl/fwp_lock_bank.sv
// Per-sector lock registers.
// Each sector holds a write-lock bit (bit 0) and a lock-down bit (bit 1).
// Once lock-down is set, that sector ignores writes until reset. Reset
// models power-up and loads LOCK_INIT.
module fwp_lock_bank #(
    parameter int         SECT_W    = 5,
    parameter logic [1:0] LOCK_INIT = 2'b00
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en_i,
    input  logic [SECT_W-1:0]        wr_sect_i,
    input  logic [1:0]               wr_bits_i,
    input  logic [SECT_W-1:0]        rd_sect_i,
    output logic [(1<<SECT_W)-1:0]   wlock_o,
    output logic [(1<<SECT_W)-1:0]   ldown_o,
    output logic [1:0]               rd_bits_o
);
    localparam int NUM_SECT = 1 << SECT_W;

    logic [1:0] lock_q [NUM_SECT];

    for (genvar g = 0; g < NUM_SECT; g++) begin : g_sect
        // Hold one sector's lock pair; frozen while its lock-down is set.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lock_q[g] <= LOCK_INIT;
            end else if (wr_en_i && (wr_sect_i == SECT_W'(g)) && !lock_q[g][1]) begin
                lock_q[g] <= wr_bits_i;
            end
        end
        assign wlock_o[g] = lock_q[g][0];
        assign ldown_o[g] = lock_q[g][1];
    end

    // Read mux for the register read port.
    assign rd_bits_o = lock_q[rd_sect_i];
endmodule

// File: rtl/fwp_status_reg.sv
// Status register storage.
// Holds the latch, write-in-progress, block-protect field and
// status-write-disable bit. The caller decides what to update; this
// module only stores the result and formats the read value.
module fwp_status_reg
    import fwp_pkg::*;
#(
    parameter int BP_W = SR_BP_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wel_upd_i,
    input  logic            wel_d_i,
    input  logic            wip_set_i,
    input  logic            wip_clr_i,
    input  logic            sr_load_i,
    input  logic            srwd_d_i,
    input  logic [BP_W-1:0] bp_d_i,
    output logic            wel_o,
    output logic            wip_o,
    output logic            srwd_o,
    output logic [BP_W-1:0] bp_o,
    output logic [7:0]      status_o
);
    // Update the status fields from the decision logic.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel_o  <= 1'b0;
            wip_o  <= 1'b0;
            srwd_o <= 1'b0;
            bp_o   <= '0;
        end else begin
            if (wel_upd_i) wel_o <= wel_d_i;
            if (wip_set_i) wip_o <= 1'b1;
            else if (wip_clr_i) wip_o <= 1'b0;
            if (sr_load_i) begin
                srwd_o <= srwd_d_i;
                bp_o   <= bp_d_i;
            end
        end
    end

    // Assemble the byte seen by readers.
    always_comb begin
        status_o = '0;
        status_o[SR_WIP]  = wip_o;
        status_o[SR_WEL]  = wel_o;
        status_o[SR_BP_LSB +: BP_W] = bp_o;
        status_o[SR_SRWD] = srwd_o;
    end
endmodule

// File: rtl/flash_wprot.sv
// Flash write protection controller (top).
// It judges each request from the command decoder against the latch,
// write-in-progress, hardware-protected mode, the block-protect range and
// the per-sector locks. It answers with a registered grant or deny one
// cycle later. Assumes single-cycle request strobes and that op_done_i
// arrives only while a self-timed cycle is running.
module flash_wprot
    import fwp_pkg::*;
#(
    parameter int         SECT_W      = 5,
    parameter int         SECT_ADDR_W = 16,
    parameter logic [1:0] LOCK_INIT   = 2'b00
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cmd_valid_i,
    input  logic [2:0]                    cmd_op_i,
    input  logic [SECT_W+SECT_ADDR_W-1:0] cmd_addr_i,
    input  logic [7:0]                    cmd_wdata_i,
    input  logic                          wp_n_i,
    input  logic                          op_done_i,
    input  logic [SECT_W-1:0]             lock_rd_sect_i,
    output logic [7:0]                    status_o,
    output logic [7:0]                    lock_rd_o,
    output logic                          grant_o,
    output logic                          deny_o
);
    localparam int ADDR_W   = SECT_W + SECT_ADDR_W;
    localparam int NUM_SECT = 1 << SECT_W;

    fwp_op_e                op;
    logic [SECT_W-1:0]      sect;
    logic                   wel, wip, srwd, hpm, bp_hit, ok;
    logic [SR_BP_W-1:0]     bp;
    logic [NUM_SECT-1:0]    wlock, ldown;
    logic [1:0]             lock_bits;
    logic                   is_timed;
    logic                   unused_addr_low;
    logic                   unused_wdata;

    assign op              = fwp_op_e'(cmd_op_i);
    assign sect            = cmd_addr_i[ADDR_W-1 -: SECT_W];
    assign hpm             = srwd && !wp_n_i;
    assign unused_addr_low = ^cmd_addr_i[SECT_ADDR_W-1:0];
    assign unused_wdata    = ^cmd_wdata_i[6:5];

    fwp_bp_decode #(.SECT_W(SECT_W), .BP_W(SR_BP_W)) bp_dec_i (
        .bp_i   (bp),
        .sect_i (sect),
        .hit_o  (bp_hit)
    );

    // Accept/refuse decision for the presented request.
    always_comb begin
        ok       = 1'b0;
        is_timed = 1'b0;
        unique case (op)
            OP_WREN, OP_WRDI: ok = 1'b1;
            OP_WRSR: begin
                ok       = wel && !hpm;
                is_timed = 1'b1;
            end
            OP_WRLR: ok = wel && !ldown[sect];
            OP_PROG, OP_SUBERASE, OP_SECTERASE: begin
                ok       = wel && !wlock[sect] && !bp_hit;
                is_timed = 1'b1;
            end
            OP_BULKERASE: begin
                ok       = wel && (bp == '0);
                is_timed = 1'b1;
            end
            default: ok = 1'b0;
        endcase
        if (wip) ok = 1'b0;
    end

    logic fire;
    assign fire = cmd_valid_i && !wip;

    fwp_status_reg #(.BP_W(SR_BP_W)) sr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wel_upd_i (fire),
        .wel_d_i   (op == OP_WREN),
        .wip_set_i (fire && ok && is_timed),
        .wip_clr_i (op_done_i),
        .sr_load_i (fire && ok && (op == OP_WRSR)),
        .srwd_d_i  (cmd_wdata_i[SR_SRWD]),
        .bp_d_i    (cmd_wdata_i[SR_BP_LSB +: SR_BP_W]),
        .wel_o     (wel),
        .wip_o     (wip),
        .srwd_o    (srwd),
        .bp_o      (bp),
        .status_o  (status_o)
    );

    fwp_lock_bank #(.SECT_W(SECT_W), .LOCK_INIT(LOCK_INIT)) lock_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (fire && ok && (op == OP_WRLR)),
        .wr_sect_i (sect),
        .wr_bits_i (cmd_wdata_i[1:0]),
        .rd_sect_i (lock_rd_sect_i),
        .wlock_o   (wlock),
        .ldown_o   (ldown),
        .rd_bits_o (lock_bits)
    );

    assign lock_rd_o = {6'b0, lock_bits};

    // Register the answer so it appears exactly one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_o <= 1'b0;
            deny_o  <= 1'b0;
        end else begin
            grant_o <= cmd_valid_i && ok;
            deny_o  <= cmd_valid_i && !ok;
        end
    end
endmodule

// File: rtl/fwp_checker.sv
// Property checker for flash_wprot, attached by bind. It watches only the
// top-level ports.
module fwp_checker
    import fwp_pkg::*;
#(
    parameter int SECT_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid_i,
    input logic [2:0]        cmd_op_i,
    input logic              wp_n_i,
    input logic [SECT_W-1:0] lock_rd_sect_i,
    input logic [7:0]        status_o,
    input logic [7:0]        lock_rd_o,
    input logic              grant_o,
    input logic              deny_o
);
    fwp_op_e op;
    assign op = fwp_op_e'(cmd_op_i);

    AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |-> !deny_o); // R12
    AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_i |=> (grant_o || deny_o)); // R12
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o || deny_o) |-> $past(cmd_valid_i)); // R12
    AST_HPM_BLOCKS_SR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && op == OP_WRSR && status_o[SR_SRWD] && !wp_n_i)
        |=> (deny_o && $stable(status_o[7:2]))); // R5
    AST_BUSY_DENIES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && status_o[SR_WIP])
        |=> (deny_o && $stable(status_o[SR_WEL]))); // R11
    AST_NO_WEL_DENIES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && op != OP_WREN && op != OP_WRDI && !status_o[SR_WEL])
        |=> deny_o); // R9
    AST_BULK_NEEDS_BP0: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && op == OP_BULKERASE && status_o[4:2] != 3'b000)
        |=> deny_o); // R10
    AST_LOCKDOWN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lock_rd_sect_i) == lock_rd_sect_i && $past(lock_rd_o[1]))
        |-> (lock_rd_o == $past(lock_rd_o))); // R7
    AST_GRANT_CLEARS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o && $past(op) != OP_WREN) |-> !status_o[SR_WEL]); // R3
endmodule

bind flash_wprot fwp_checker #(.SECT_W(SECT_W)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_valid_i    (cmd_valid_i),
    .cmd_op_i       (cmd_op_i),
    .wp_n_i         (wp_n_i),
    .lock_rd_sect_i (lock_rd_sect_i),
    .status_o       (status_o),
    .lock_rd_o      (lock_rd_o),
    .grant_o        (grant_o),
    .deny_o         (deny_o)
);

// File: tb/flash_wprot_tb_top.sv
// Scoreboard bench for flash_wprot: the driver queues the expected answer
// and status, and the monitor compares them one cycle after each request.
module flash_wprot_tb_top;
    import fwp_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [20:0] cmd_addr = '0;
    logic [7:0]  cmd_wdata = '0;
    logic        wp_n = 1'b1;
    logic        op_done = 1'b0;
    logic [4:0]  rd_sect = '0;
    logic [7:0]  status, lock_rd;
    logic        grant, deny;

    always #5 clk = ~clk;

    flash_wprot dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
        .cmd_addr_i(cmd_addr), .cmd_wdata_i(cmd_wdata), .wp_n_i(wp_n),
        .op_done_i(op_done), .lock_rd_sect_i(rd_sect), .status_o(status),
        .lock_rd_o(lock_rd), .grant_o(grant), .deny_o(deny)
    );

    typedef struct {
        int         due;
        logic       g;
        logic [7:0] st;
        string      tag;
    } exp_t;

    exp_t sb_q[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done_flag = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: pop the expected item that falls due and compare.
    exp_t cur;
    always @(negedge clk) begin
        if (sb_q.size() > 0 && sb_q[0].due == cyc) begin
            cur = sb_q.pop_front();
            check(grant == cur.g && deny == !cur.g, cur.tag, "response",
                  {14'b0, grant, deny}, {14'b0, cur.g, !cur.g});
            check(status == cur.st, cur.tag, "status", {8'b0, status}, {8'b0, cur.st});
        end else if (rst_n && (grant || deny)) begin
            check(1'b0, "R12", "unrequested response", {14'b0, grant, deny}, 16'h0);
        end
    end

    // Driver: present one request and queue what must come back.
    task automatic req(input fwp_op_e op, input int sect, input logic [7:0] d,
                       input logic g, input logic [7:0] st, input string tag);
        exp_t e;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_addr  = {5'(sect), 16'h5A3C};
        cmd_wdata = d;
        e.due = cyc + 1; e.g = g; e.st = st; e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic finish_cycle(input logic [7:0] st, input string tag);
        @(negedge clk); op_done = 1'b1;
        @(negedge clk); op_done = 1'b0;
        check(status == st, tag, "status after done", {8'b0, status}, {8'b0, st});
    endtask

    task automatic chk_lock(input int sect, input logic [7:0] exp, input string tag);
        rd_sect = 5'(sect);
        #1;
        check(lock_rd == exp, tag, "lock read", {8'b0, lock_rd}, {8'b0, exp});
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic report();
        if (!done_flag) begin
            done_flag = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        check(1'b0, "R12", "watchdog expired", 16'h0, 16'h1);
        report();
    end

    initial begin
        do_reset();
        // R1 reset state
        check(status == 8'h00, "R1", "status", {8'b0, status}, 16'h0);
        check(!grant && !deny, "R1", "pulses", {14'b0, grant, deny}, 16'h0);
        chk_lock(0, 8'h00, "R1");
        chk_lock(31, 8'h00, "R1");
        // R4 no latch; R3 latch set/clear
        req(OP_WRSR, 0, 8'h1C, 0, 8'h00, "R4");
        req(OP_WREN, 0, 8'h00, 1, 8'h02, "R3");
        req(OP_WRDI, 0, 8'h00, 1, 8'h00, "R3");
        // R4/R2 status write; spare data bits ignored
        req(OP_WREN, 0, 8'h00, 1, 8'h02, "R3");
        req(OP_WRSR, 0, 8'hFF, 1, 8'h9D, "R2");
        // R11 busy
        req(OP_WREN, 0, 8'h00, 0, 8'h9D, "R11");
        req(OP_PROG, 3, 8'h00, 0, 8'h9D, "R11");
        finish_cycle(8'h9C, "R11");
        // R5 hardware-protected mode
        wp_n = 1'b0;
        req(OP_WREN, 0, 8'h00, 1, 8'h9E, "R5");
        req(OP_WRSR, 0, 8'h00, 0, 8'h9C, "R5");
        wp_n = 1'b1;
        req(OP_WREN, 0, 8'h00, 1, 8'h9E, "R4");
        req(OP_WRSR, 0, 8'h84, 1, 8'h85, "R4");
        finish_cycle(8'h84, "R4");
        // R8 span of one sector
        req(OP_WREN, 0, 8'h00, 1, 8'h86, "R3");
        req(OP_PROG, 31, 8'h00, 0, 8'h84, "R8");
        req(OP_WREN, 0, 8'h00, 1, 8'h86, "R3");
        req(OP_PROG, 30, 8'h00, 1, 8'h85, "R8");
        finish_cycle(8'h84, "R9");
        // R10 bulk erase refused with nonzero field
        req(OP_WREN, 0, 8'h00, 1, 8'h86, "R3");
        req(OP_BULKERASE, 0, 8'h00, 0, 8'h84, "R10");
        // R8 span of four sectors
        req(OP_WREN, 0, 8'h00, 1, 8'h86, "R3");
        req(OP_WRSR, 0, 8'h0C, 1, 8'h0D, "R4");
        finish_cycle(8'h0C, "R4");
        req(OP_WREN, 0, 8'h00, 1, 8'h0E, "R3");
        req(OP_SECTERASE, 28, 8'h00, 0, 8'h0C, "R8");
        req(OP_WREN, 0, 8'h00, 1, 8'h0E, "R3");
        req(OP_SUBERASE, 27, 8'h00, 1, 8'h0D, "R8");
        finish_cycle(8'h0C, "R9");
        // R8 capped spans 6 and 7
        req(OP_WREN, 0, 8'h00, 1, 8'h0E, "R3");
        req(OP_WRSR, 0, 8'h18, 1, 8'h19, "R4");
        finish_cycle(8'h18, "R4");
        req(OP_WREN, 0, 8'h00, 1, 8'h1A, "R3");
        req(OP_PROG, 0, 8'h00, 0, 8'h18, "R8");
        req(OP_WREN, 0, 8'h00, 1, 8'h1A, "R3");
        req(OP_WRSR, 0, 8'h1C, 1, 8'h1D, "R4");
        finish_cycle(8'h1C, "R4");
        req(OP_WREN, 0, 8'h00, 1, 8'h1E, "R3");
        req(OP_PROG, 0, 8'h00, 0, 8'h1C, "R8");
        req(OP_WREN, 0, 8'h00, 1, 8'h1E, "R3");
        req(OP_WRSR, 0, 8'h00, 1, 8'h01, "R4");
        finish_cycle(8'h00, "R4");
        // R9 no latch
        req(OP_PROG, 5, 8'h00, 0, 8'h00, "R9");
        // R6 lock write, upper data bits ignored
        req(OP_WREN, 0, 8'h00, 1, 8'h02, "R3");
        req(OP_WRLR, 5, 8'hFD, 1, 8'h00, "R6");
        chk_lock(5, 8'h01, "R6");
        req(OP_WREN, 0, 8'h00, 1, 8'h02, "R3");
        req(OP_PROG, 5, 8'h00, 0, 8'h00, "R9");
        req(OP_WREN, 0, 8'h00, 1, 8'h02, "R3");
        req(OP_PROG, 6, 8'h00, 1, 8'h01, "R9");
        finish_cycle(8'h00, "R9");
        // R7 lock-down
        req(OP_WREN, 0, 8'h00, 1, 8'h02, "R3");
        req(OP_WRLR, 5, 8'h02, 1, 8'h00, "R7");
        chk_lock(5, 8'h02, "R7");
        req(OP_WREN, 0, 8'h00, 1, 8'h02, "R3");
        req(OP_WRLR, 5, 8'h01, 0, 8'h00, "R7");
        chk_lock(5, 8'h02, "R7");
        req(OP_WRLR, 7, 8'h03, 0, 8'h00, "R6");
        chk_lock(7, 8'h00, "R6");
        req(OP_WREN, 0, 8'h00, 1, 8'h02, "R3");
        req(OP_PROG, 5, 8'h00, 1, 8'h01, "R9");
        finish_cycle(8'h00, "R9");
        // R10 bulk erase with field 0
        req(OP_WREN, 0, 8'h00, 1, 8'h02, "R3");
        req(OP_BULKERASE, 0, 8'h00, 1, 8'h01, "R10");
        finish_cycle(8'h00, "R10");
        // R7 lock-down released only by reset
        do_reset();
        chk_lock(5, 8'h00, "R7");
        check(status == 8'h00, "R1", "status after second reset", {8'b0, status}, 16'h0);
        repeat (3) @(negedge clk);
        check(sb_q.size() == 0, "R12", "answers outstanding", 16'(sb_q.size()), 16'h0);
        report();
    end
endmodule